// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block holds the interrupt flags of two timer/counters: a 16-bit timer with input capture, two compare channels and an overflow event, and an 8-bit timer with an overflow event. The timer logic sends it single-cycle event pulses. Each pulse sets a sticky flag. The flag stays set until software writes a one to its bit, or until the CPU acknowledges the matching interrupt vector.

A request line for a source goes high when three things are all 1: the global interrupt enable, that source's enable bit and its flag. When more than one request is active, a fixed priority picks one. The block reports the bit position of that source, which the CPU returns with its acknowledge. The source of the 16-bit overflow event depends on the timer's mode. In the normal modes it is the counter wrap pulse. In up/down PWM mode it is the pulse that marks the counter leaving zero.

Top module: `tmr_irq_flags`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `rd_data`, `irq_req` and `irq_any` are all zero.
- R2: An event pulse sets its flag on the next clock edge, and the flag stays set with no further pulses. Bit positions in `rd_data`: 5 capture, 4 compare A, 3 compare B, 2 16-bit overflow, 0 8-bit overflow.
- R3: A write with `wr_en` high clears every flag whose `wr_data` bit is 1. Flags whose `wr_data` bit is 0 keep their value.
- R4: An acknowledge (`ack_valid` high) clears only the flag at bit position `ack_id`. All other flags keep their value.
- R5: When a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R6: `irq_req[i]` is high exactly when `gie`, `irq_en[i]` and flag bit i are all 1. `irq_req` uses the same bit positions as `rd_data`.
- R7: When `t16_updown_pwm` is 0, the 16-bit overflow flag sets on `t16_wrap` and ignores `t16_leave_zero`. When `t16_updown_pwm` is 1, it sets on `t16_leave_zero` and ignores `t16_wrap`.
- R8: Bits 7, 6 and 1 of `rd_data` and `irq_req` always read 0. Writes, acknowledges (`ack_id` 1, 6, 7) and enables aimed at these bits have no effect.
- R9: `irq_any` is high when any request is active. `irq_sel` then gives the highest active bit position, so the priority order is capture, compare A, compare B, 16-bit overflow, 8-bit overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_capture | input | 1 | Input capture completed pulse |
| evt_cmp_a | input | 1 | Compare A match pulse |
| evt_cmp_b | input | 1 | Compare B match pulse |
| t16_wrap | input | 1 | 16-bit counter wrap pulse (normal modes) |
| t16_leave_zero | input | 1 | 16-bit counter leaves zero pulse (up/down PWM) |
| t16_updown_pwm | input | 1 | 16-bit timer is in up/down PWM mode |
| evt_t8_ovf | input | 1 | 8-bit counter overflow pulse |
| gie | input | 1 | Global interrupt enable |
| irq_en | input | 8 | Per-flag interrupt enables, same layout as the flags |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Write data; a 1 clears the flag at that bit |
| ack_valid | input | 1 | CPU vectored to an interrupt |
| ack_id | input | 3 | Bit position of the acknowledged flag |
| rd_data | output | 8 | Flag register read value |
| irq_req | output | 8 | Per-source request lines |
| irq_any | output | 1 | At least one request is active |
| irq_sel | output | 3 | Bit position of the highest-priority active request |

## Verification
The flags are the only state in this block. A flag that is wrong shows on `rd_data` one clock edge after the event or clear that caused it. If the flag's enable is set and `gie` is high, the error also shows on `irq_req`, `irq_any` and `irq_sel` in that same cycle. Because of this, each directed scenario samples the outputs right after the edge that follows its stimulus. A lost event, a missed clear or a write that reaches a reserved bit therefore shows up within one cycle. It does not stay hidden until some later interrupt is dispatched. The priority order is checked by acknowledging sources one at a time and watching `irq_sel` step down from the highest bit position to the lowest.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int FLAG_REG_W = 8;
  localparam int POS_CAP    = 5;
  localparam int POS_CMPA   = 4;
  localparam int POS_CMPB   = 3;
  localparam int POS_OVF16  = 2;
  localparam int POS_RSVD   = 1;
  localparam int POS_OVF8   = 0;

  // Mask of the bit positions that hold a real flag.
  function automatic logic [FLAG_REG_W-1:0] impl_mask();
    logic [FLAG_REG_W-1:0] m;
    m            = '0;
    m[POS_CAP]   = 1'b1;
    m[POS_CMPA]  = 1'b1;
    m[POS_CMPB]  = 1'b1;
    m[POS_OVF16] = 1'b1;
    m[POS_OVF8]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tif_event_map.sv
module tif_event_map
  import tif_pkg::*;
#(
  parameter int REG_W = FLAG_REG_W
) (
  input  logic             evt_capture,
  input  logic             evt_cmp_a,
  input  logic             evt_cmp_b,
  input  logic             t16_wrap,
  input  logic             t16_leave_zero,
  input  logic             t16_updown_pwm,
  input  logic             evt_t8_ovf,
  output logic [REG_W-1:0] set_vec
);
  logic ovf16_evt;

  // The 16-bit overflow event source depends on the counting mode.
  always_comb begin
    if (t16_updown_pwm) ovf16_evt = t16_leave_zero;
    else                ovf16_evt = t16_wrap;
  end

  always_comb begin
    set_vec            = '0;
    set_vec[POS_CAP]   = evt_capture;
    set_vec[POS_CMPA]  = evt_cmp_a;
    set_vec[POS_CMPB]  = evt_cmp_b;
    set_vec[POS_OVF16] = ovf16_evt;
    set_vec[POS_OVF8]  = evt_t8_ovf;
  end
endmodule

// File: rtl/tif_clr_decode.sv
module tif_clr_decode
  import tif_pkg::*;
#(
  parameter int REG_W = FLAG_REG_W,
  parameter int ID_W  = $clog2(REG_W)
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ack_valid,
  input  logic [ID_W-1:0]  ack_id,
  output logic [REG_W-1:0] clr_vec
);
  localparam logic [REG_W-1:0] MASK = REG_W'(impl_mask());

  logic [REG_W-1:0] wr_clr;
  logic [REG_W-1:0] ack_clr;

  always_comb begin
    wr_clr = wr_en ? wr_data : '0;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_ack
    assign ack_clr[i] = ack_valid && (ack_id == ID_W'(i));
  end

  // Reserved positions never see a clear.
  always_comb begin
    clr_vec = (wr_clr | ack_clr) & MASK;
  end
endmodule

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic upd;
  logic flag_d;

  // A set beats a clear in the same cycle.
  always_comb begin
    upd    = set_i | clr_i;
    flag_d = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (upd) flag_q <= flag_d;
  end
endmodule

// File: rtl/tif_prio_sel.sv
module tif_prio_sel #(
  parameter int REG_W = 8,
  parameter int ID_W  = $clog2(REG_W)
) (
  input  logic [REG_W-1:0] pend,
  output logic             any,
  output logic [ID_W-1:0]  sel
);
  // The highest set position wins: the last one seen in an upward scan.
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (pend[i]) begin
        any = 1'b1;
        sel = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tif_pkg::*;
#(
  parameter int REG_W = FLAG_REG_W,
  parameter int ID_W  = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_capture,
  input  logic             evt_cmp_a,
  input  logic             evt_cmp_b,
  input  logic             t16_wrap,
  input  logic             t16_leave_zero,
  input  logic             t16_updown_pwm,
  input  logic             evt_t8_ovf,
  input  logic             gie,
  input  logic [REG_W-1:0] irq_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ack_valid,
  input  logic [ID_W-1:0]  ack_id,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] irq_req,
  output logic             irq_any,
  output logic [ID_W-1:0]  irq_sel
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flags;

  tif_event_map #(.REG_W(REG_W)) u_map (
    .evt_capture    (evt_capture),
    .evt_cmp_a      (evt_cmp_a),
    .evt_cmp_b      (evt_cmp_b),
    .t16_wrap       (t16_wrap),
    .t16_leave_zero (t16_leave_zero),
    .t16_updown_pwm (t16_updown_pwm),
    .evt_t8_ovf     (evt_t8_ovf),
    .set_vec        (set_vec)
  );

  tif_clr_decode #(.REG_W(REG_W), .ID_W(ID_W)) u_clr (
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .clr_vec   (clr_vec)
  );

  for (genvar i = 0; i < REG_W; i++) begin : g_flag
    tif_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .clr_i  (clr_vec[i]),
      .flag_q (flags[i])
    );
  end

  always_comb begin
    rd_data = flags;
    irq_req = gie ? (flags & irq_en) : '0;
  end

  tif_prio_sel #(.REG_W(REG_W), .ID_W(ID_W)) u_prio (
    .pend (irq_req),
    .any  (irq_any),
    .sel  (irq_sel)
  );
endmodule

// File: rtl/tif_checker.sv
module tif_checker
  import tif_pkg::*;
#(
  parameter int REG_W = FLAG_REG_W,
  parameter int ID_W  = $clog2(REG_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_capture,
  input logic             evt_cmp_a,
  input logic             evt_cmp_b,
  input logic             t16_wrap,
  input logic             t16_leave_zero,
  input logic             t16_updown_pwm,
  input logic             gie,
  input logic [REG_W-1:0] irq_en,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             ack_valid,
  input logic [ID_W-1:0]  ack_id,
  input logic [REG_W-1:0] rd_data,
  input logic [REG_W-1:0] irq_req,
  input logic             irq_any,
  input logic [ID_W-1:0]  irq_sel
);
  AST_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_capture |=> rd_data[POS_CAP]); // R2
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_cmp_a && wr_en && wr_data[POS_CMPA]) |=> rd_data[POS_CMPA]); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[POS_CMPA] && !evt_cmp_a) |=> !rd_data[POS_CMPA]); // R3
  AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[POS_CMPB] && !(wr_en && wr_data[POS_CMPB])
     && !(ack_valid && ack_id == ID_W'(POS_CMPB))) |=> rd_data[POS_CMPB]); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_id == ID_W'(POS_CAP) && !evt_capture) |=> !rd_data[POS_CAP]); // R4
  AST_CMPB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmp_b |=> rd_data[POS_CMPB]); // R2
  AST_PWM_WRAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (t16_updown_pwm && t16_wrap && !t16_leave_zero && !rd_data[POS_OVF16])
    |=> !rd_data[POS_OVF16]); // R7
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0)); // R6
  AST_REQ_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~(rd_data & irq_en)) == '0); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] && !rd_data[6] && !rd_data[POS_RSVD] && !irq_req[POS_RSVD]); // R8
  AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (irq_req[irq_sel] && (((irq_req >> irq_sel) >> 1) == '0))); // R9
  AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_req != '0)); // R9
endmodule

bind tmr_irq_flags tif_checker #(.REG_W(REG_W), .ID_W(ID_W)) u_tif_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .evt_capture    (evt_capture),
  .evt_cmp_a      (evt_cmp_a),
  .evt_cmp_b      (evt_cmp_b),
  .t16_wrap       (t16_wrap),
  .t16_leave_zero (t16_leave_zero),
  .t16_updown_pwm (t16_updown_pwm),
  .gie            (gie),
  .irq_en         (irq_en),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .ack_valid      (ack_valid),
  .ack_id         (ack_id),
  .rd_data        (rd_data),
  .irq_req        (irq_req),
  .irq_any        (irq_any),
  .irq_sel        (irq_sel)
);

// File: tb/tmr_irq_flags_bench.sv
module tmr_irq_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_capture = 1'b0, evt_cmp_a = 1'b0, evt_cmp_b = 1'b0;
  logic       t16_wrap = 1'b0, t16_leave_zero = 1'b0, t16_updown_pwm = 1'b0;
  logic       evt_t8_ovf = 1'b0, gie = 1'b0;
  logic [7:0] irq_en = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_id = '0;
  logic [7:0] rd_data, irq_req;
  logic       irq_any;
  logic [2:0] irq_sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tmr_irq_flags u_tmr_irq_flags (
    .clk(clk), .rst_n(rst_n), .evt_capture(evt_capture), .evt_cmp_a(evt_cmp_a),
    .evt_cmp_b(evt_cmp_b), .t16_wrap(t16_wrap), .t16_leave_zero(t16_leave_zero),
    .t16_updown_pwm(t16_updown_pwm), .evt_t8_ovf(evt_t8_ovf), .gie(gie),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .ack_valid(ack_valid),
    .ack_id(ack_id), .rd_data(rd_data), .irq_req(irq_req), .irq_any(irq_any),
    .irq_sel(irq_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One clock edge; afterwards all pulse inputs are dropped.
  task automatic step();
    @(posedge clk);
    #2;
    evt_capture = 0; evt_cmp_a = 0; evt_cmp_b = 0; t16_wrap = 0;
    t16_leave_zero = 0; evt_t8_ovf = 0; wr_en = 0; wr_data = '0; ack_valid = 0;
  endtask

  task automatic write_reg(input logic [7:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  task automatic ack(input logic [2:0] id);
    ack_valid = 1; ack_id = id; step();
  endtask

  task automatic set_all();
    t16_updown_pwm = 0;
    evt_capture = 1; evt_cmp_a = 1; evt_cmp_b = 1; t16_wrap = 1; evt_t8_ovf = 1;
    step();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 rd_data in reset", rd_data, 8'h00);
    chk("R1 irq_req in reset", irq_req, 8'h00);
    chk("R1 irq_any in reset", irq_any, 1'b0);
    @(posedge clk); #2; rst_n = 1;
    step();
    chk("R1 rd_data after release", rd_data, 8'h00);
  endtask

  task automatic t_set_each();
    evt_capture = 1; step(); chk("R2 capture bit5", rd_data, 8'h20);
    step();               chk("R2 capture sticky", rd_data, 8'h20);
    write_reg(8'hFF);
    evt_cmp_a = 1; step(); chk("R2 compare A bit4", rd_data, 8'h10);
    write_reg(8'hFF);
    evt_cmp_b = 1; step(); chk("R2 compare B bit3", rd_data, 8'h08);
    write_reg(8'hFF);
    t16_wrap = 1; step();  chk("R2 16-bit overflow bit2", rd_data, 8'h04);
    write_reg(8'hFF);
    evt_t8_ovf = 1; step(); chk("R2 8-bit overflow bit0", rd_data, 8'h01);
    write_reg(8'hFF);
    chk("R3 clear all", rd_data, 8'h00);
  endtask

  task automatic t_w1c();
    set_all();            chk("R2 all flags", rd_data, 8'h3D);
    write_reg(8'h00);     chk("R3 write zero keeps", rd_data, 8'h3D);
    write_reg(8'h10);     chk("R3 write one clears bit4", rd_data, 8'h2D);
    write_reg(8'hC2);     chk("R8 reserved write no effect", rd_data, 8'h2D);
    write_reg(8'h21);     chk("R3 clear bits5,0", rd_data, 8'h0C);
    write_reg(8'hFF);     chk("R3 clear rest", rd_data, 8'h00);
  endtask

  task automatic t_ack();
    set_all();
    ack(3'd4);            chk("R4 ack 4 clears only bit4", rd_data, 8'h2D);
    ack(3'd1);            chk("R8 ack reserved 1", rd_data, 8'h2D);
    ack(3'd7);            chk("R8 ack reserved 7", rd_data, 8'h2D);
    ack(3'd0);            chk("R4 ack 0", rd_data, 8'h2C);
    write_reg(8'hFF);
  endtask

  task automatic t_set_wins();
    evt_capture = 1; wr_en = 1; wr_data = 8'h20; step();
    chk("R5 set beats write-one", rd_data, 8'h20);
    evt_capture = 1; ack_valid = 1; ack_id = 3'd5; step();
    chk("R5 set beats ack", rd_data, 8'h20);
    evt_t8_ovf = 1; wr_en = 1; wr_data = 8'h20; step();
    chk("R5 other bit clears while set", rd_data, 8'h01);
    write_reg(8'hFF);
  endtask

  task automatic t_req();
    set_all();
    irq_en = 8'hFF; gie = 0; #1;
    chk("R6 gie low blocks", irq_req, 8'h00);
    gie = 1; #1;
    chk("R6 all enabled", irq_req, 8'h3D);
    irq_en = 8'h14; #1;
    chk("R6 partial enable", irq_req, 8'h14);
    irq_en = 8'hC2; #1;
    chk("R8 reserved enables", irq_req, 8'h00);
    chk("R9 no request any low", irq_any, 1'b0);
    irq_en = 8'h00; gie = 0;
    write_reg(8'hFF);
  endtask

  task automatic t_pwm();
    t16_updown_pwm = 1;
    t16_wrap = 1; step();       chk("R7 pwm ignores wrap", rd_data, 8'h00);
    t16_leave_zero = 1; step(); chk("R7 pwm leave zero sets", rd_data, 8'h04);
    write_reg(8'hFF);
    t16_updown_pwm = 0;
    t16_leave_zero = 1; step(); chk("R7 normal ignores leave zero", rd_data, 8'h00);
    t16_wrap = 1; step();       chk("R7 normal wrap sets", rd_data, 8'h04);
    write_reg(8'hFF);
  endtask

  task automatic t_prio();
    set_all();
    gie = 1; irq_en = 8'hFF; #1;
    chk("R9 any", irq_any, 1'b1);
    chk("R9 sel capture", irq_sel, 3'd5);
    irq_en = 8'hDF; #1;
    chk("R9 sel masked capture", irq_sel, 3'd4);
    irq_en = 8'hFF;
    ack(3'd5); chk("R9 sel compare A", irq_sel, 3'd4);
    ack(3'd4); chk("R9 sel compare B", irq_sel, 3'd3);
    ack(3'd3); chk("R9 sel 16-bit ovf", irq_sel, 3'd2);
    ack(3'd2); chk("R9 sel 8-bit ovf", irq_sel, 3'd0);
    chk("R9 any on bit0", irq_any, 1'b1);
    ack(3'd0); chk("R9 none left", irq_any, 1'b0);
    gie = 0; irq_en = 8'h00;
  endtask

  task automatic t_async_reset();
    set_all();
    #1 rst_n = 0; #1;
    chk("R1 async reset clears", rd_data, 8'h00);
    @(posedge clk); #2; rst_n = 1;
    step();
    chk("R1 stays clear after release", rd_data, 8'h00);
  endtask

  initial begin
    t_reset();
    t_set_each();
    t_w1c();
    t_ack();
    t_set_wins();
    t_req();
    t_pwm();
    t_prio();
    t_async_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule